// File: doc/BRIEF.md
# Expansion-port chip-select decoder

This block sits between a console's parallel expansion bus and the devices of an add-on board. It turns the bus address, the read and write strobes, a region-select input and a boot-region-select input into one chip select per device. The devices are a soldered flash, a socketed flash and an SRAM, plus the data and control registers of two channels of a dual-channel USB FIFO bridge and of a USB host controller. A decoded address bit, `dev_ctrl`, tells the selected register device whether the control or the data register is meant.

The block also owns two local byte registers. One is an LED output latch that reads back as the inverted DIP switch inputs. The other is an 8-bit configuration register. Bit 0 of the configuration register moves boot-region accesses from the socketed flash to the SRAM. A board-strap input must be high before the boot-region select is honoured at all. All bus inputs are sampled on `clk`, and every output is registered, so a decoded select appears one clock after the access is sampled.

Top module: `exp_cs_decoder`

## Requirements
- R1: With `region_sel` high and `bus_rd` or `bus_wr` high, offsets 0x000000 to 0x1FFFFF assert `cs_fixed_flash` one clock later.
- R2: Under the same conditions, offsets 0x200000 to 0x3FFFFF assert `cs_socket_flash`.
- R3: Under the same conditions, offsets 0x400000 to 0x5FFFFF assert `cs_sram`.
- R4: Offsets 0x600000/1 assert `cs_fifo_a`, 0x600002/3 assert `cs_fifo_b`, and 0x600004/5 assert `cs_usb_host`. `dev_ctrl` follows address bit 0, where 1 means the control register.
- R5: A write to offset 0x600006 latches `bus_wdata` onto `led`. A read of it returns the bitwise inverse of `dip_sw`.
- R6: Offset 0x600007 is an 8-bit read/write configuration register that resets to 0x00.
- R7: With `board_strap` high and `boot_sel` high during a strobe, configuration bit 0 = 0 asserts `cs_socket_flash`, and bit 0 = 1 asserts `cs_sram`. The boot-region select takes priority over `region_sel`.
- R8: With `board_strap` low, `boot_sel` is ignored, so a boot-only access asserts no select and `region_sel` decoding proceeds unchanged.
- R9: At most one chip select is high at a time. No select is high without a strobe. Offsets 0x600008 to 0x7FFFFF assert no select, and a read of them returns 0xFF.
- R10: Local register writes happen once, on the clock where `bus_wr` rises, and a held strobe writes nothing more. `bus_rdata_oe` goes high one clock after a read of offset 6, offset 7 or an unmapped window offset, and stays low for all other accesses.
- R11: After reset all selects and `bus_rdata_oe` are low and `led` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 23 | Byte offset inside the 8 MB expansion region |
| bus_wdata | input | 8 | Write data from the bus |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| region_sel | input | 1 | Expansion-region access |
| boot_sel | input | 1 | Boot-ROM-region access |
| board_strap | input | 1 | Strap that enables boot-region decoding |
| dip_sw | input | 8 | DIP switch inputs |
| bus_rdata | output | 8 | Read data for local registers and holes |
| bus_rdata_oe | output | 1 | Read data drive enable |
| led | output | 8 | LED latch |
| cs_fixed_flash | output | 1 | Soldered flash select |
| cs_socket_flash | output | 1 | Socketed flash select |
| cs_sram | output | 1 | SRAM select |
| cs_fifo_a | output | 1 | FIFO bridge channel A select |
| cs_fifo_b | output | 1 | FIFO bridge channel B select |
| cs_usb_host | output | 1 | USB host controller select |
| dev_ctrl | output | 1 | 1 = control register, 0 = data register |

## Verification
`boot_sel` and `region_sel` can both be high in the same cycle, so the boot-region remap and the normal window decode compete for the single select. The bench raises both together while pointing the address at the soldered flash. It does this once with the strap high, where the boot target must win and follow configuration bit 0, and once with the strap low, where the soldered flash must be selected. It also issues a boot access on the bus cycle right after the configuration write that flips bit 0, and judges that the new target is already in effect.

// File: rtl/exp_cs_pkg.sv
package exp_cs_pkg;
  typedef enum logic [2:0] {
    DEV_NONE   = 3'd0,
    DEV_FIXED  = 3'd1,
    DEV_SOCKET = 3'd2,
    DEV_SRAM   = 3'd3,
    DEV_FIFO_A = 3'd4,
    DEV_FIFO_B = 3'd5,
    DEV_USBH   = 3'd6,
    DEV_LOCAL  = 3'd7
  } dev_e;

  localparam int unsigned NUM_CS = 6;

  typedef struct packed {
    dev_e dev;
    logic hit_led;
    logic hit_cfg;
    logic hole;
  } decode_t;
endpackage

// File: rtl/exp_addr_decode.sv
module exp_addr_decode
  import exp_cs_pkg::*;
#(
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned REG_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              region_sel,
  input  logic              boot_sel,
  input  logic              board_strap,
  input  logic              boot_to_sram,
  output decode_t           dec
);
  localparam int unsigned OFF_W = ADDR_W - BANK_W;
  localparam int unsigned PAIR_W = REG_W - 1;

  logic [BANK_W-1:0] bank;
  logic              in_window;
  logic [PAIR_W-1:0] pair;

  assign bank      = addr[ADDR_W-1 -: BANK_W];
  assign in_window = (addr[OFF_W-1:REG_W] == '0);
  assign pair      = addr[REG_W-1:1];

  always_comb begin
    dec = '{dev: DEV_NONE, hit_led: 1'b0, hit_cfg: 1'b0, hole: 1'b0};
    if (board_strap && boot_sel) begin
      dec.dev = boot_to_sram ? DEV_SRAM : DEV_SOCKET;
    end else if (region_sel) begin
      case (bank)
        2'd0: dec.dev = DEV_FIXED;
        2'd1: dec.dev = DEV_SOCKET;
        2'd2: dec.dev = DEV_SRAM;
        default: begin
          if (!in_window) begin
            dec.hole = 1'b1;
          end else begin
            case (pair)
              2'd0: dec.dev = DEV_FIFO_A;
              2'd1: dec.dev = DEV_FIFO_B;
              2'd2: dec.dev = DEV_USBH;
              default: begin
                dec.dev     = DEV_LOCAL;
                dec.hit_led = ~addr[0];
                dec.hit_cfg = addr[0];
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/exp_local_regs.sv
module exp_local_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              hit_led,
  input  logic              hit_cfg,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] led,
  output logic [DATA_W-1:0] cfg
);
  logic wr_q;
  logic wr_rise;

  assign wr_rise = wr & ~wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b0;
      led  <= '0;
      cfg  <= '0;
    end else begin
      wr_q <= wr;
      if (wr_rise && hit_led) led <= wdata;
      if (wr_rise && hit_cfg) cfg <= wdata;
    end
  end

  // R5
  led_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !wr_q && hit_led) |=> (led == $past(wdata)));

  // R10
  held_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && wr_q) |=> ($stable(led) && $stable(cfg)));
endmodule

// File: rtl/exp_read_port.sv
module exp_read_port #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              hit_led,
  input  logic              hit_cfg,
  input  logic              hole,
  input  logic [DATA_W-1:0] dip_sw,
  input  logic [DATA_W-1:0] cfg,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '1;
      rdata_oe <= 1'b0;
    end else begin
      rdata_oe <= rd && (hit_led || hit_cfg || hole);
      if (hit_led)      rdata <= ~dip_sw;
      else if (hit_cfg) rdata <= cfg;
      else              rdata <= '1;
    end
  end

  // R10
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> $past(rd));
endmodule

// File: rtl/exp_cs_decoder.sv
module exp_cs_decoder
  import exp_cs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 23,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned REG_W    = 3,
  parameter int unsigned BOOT_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              region_sel,
  input  logic              boot_sel,
  input  logic              board_strap,
  input  logic [DATA_W-1:0] dip_sw,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  output logic [DATA_W-1:0] led,
  output logic              cs_fixed_flash,
  output logic              cs_socket_flash,
  output logic              cs_sram,
  output logic              cs_fifo_a,
  output logic              cs_fifo_b,
  output logic              cs_usb_host,
  output logic              dev_ctrl
);
  decode_t           dec;
  logic [DATA_W-1:0] cfg;
  logic              strobe;
  logic [NUM_CS-1:0] cs_q;
  logic              ctrl_q;

  assign strobe = bus_rd | bus_wr;

  exp_addr_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_dec (
    .addr         (bus_addr),
    .region_sel   (region_sel),
    .boot_sel     (boot_sel),
    .board_strap  (board_strap),
    .boot_to_sram (cfg[BOOT_BIT]),
    .dec          (dec)
  );

  exp_local_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .hit_led (dec.hit_led),
    .hit_cfg (dec.hit_cfg),
    .wdata   (bus_wdata),
    .led     (led),
    .cfg     (cfg)
  );

  exp_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .hit_led  (dec.hit_led),
    .hit_cfg  (dec.hit_cfg),
    .hole     (dec.hole),
    .dip_sw   (dip_sw),
    .cfg      (cfg),
    .rdata    (bus_rdata),
    .rdata_oe (bus_rdata_oe)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) cs_q[i] <= 1'b0;
      else     cs_q[i] <= strobe && (dec.dev == dev_e'(i + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= 1'b0;
    else     ctrl_q <= bus_addr[0];
  end

  assign cs_fixed_flash  = cs_q[0];
  assign cs_socket_flash = cs_q[1];
  assign cs_sram         = cs_q[2];
  assign cs_fifo_a       = cs_q[3];
  assign cs_fifo_b       = cs_q[4];
  assign cs_usb_host     = cs_q[5];
  assign dev_ctrl        = ctrl_q;

  // R9
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cs_fixed_flash, cs_socket_flash, cs_sram,
              cs_fifo_a, cs_fifo_b, cs_usb_host}));

  // R9
  no_strobe_no_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd || bus_wr) |=> !(cs_fixed_flash || cs_socket_flash || cs_sram ||
                              cs_fifo_a || cs_fifo_b || cs_usb_host));

  // R8
  strap_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!board_strap && boot_sel && !region_sel) |=>
      !(cs_fixed_flash || cs_socket_flash || cs_sram ||
        cs_fifo_a || cs_fifo_b || cs_usb_host));

  // R7
  boot_target_chk: assert property (@(posedge clk) disable iff (rst)
    (board_strap && boot_sel && (bus_rd || bus_wr)) |=>
      (cs_sram == $past(cfg[BOOT_BIT])) && (cs_socket_flash == !$past(cfg[BOOT_BIT])));
endmodule

// File: tb/sim_exp_cs_decoder.sv
module sim_exp_cs_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [22:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic        region_sel = 1'b0, boot_sel = 1'b0, board_strap = 1'b1;
  logic [7:0]  dip_sw = '0;
  logic [7:0]  bus_rdata, led;
  logic        bus_rdata_oe, dev_ctrl;
  logic        cs_fixed_flash, cs_socket_flash, cs_sram, cs_fifo_a, cs_fifo_b, cs_usb_host;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exp_cs_decoder u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .region_sel(region_sel), .boot_sel(boot_sel),
    .board_strap(board_strap), .dip_sw(dip_sw), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .led(led), .cs_fixed_flash(cs_fixed_flash),
    .cs_socket_flash(cs_socket_flash), .cs_sram(cs_sram), .cs_fifo_a(cs_fifo_a),
    .cs_fifo_b(cs_fifo_b), .cs_usb_host(cs_usb_host), .dev_ctrl(dev_ctrl)
  );

  // select vector order: fixed, socket, sram, fifo_a, fifo_b, usb_host
  function automatic logic [5:0] cs_vec();
    return {cs_fixed_flash, cs_socket_flash, cs_sram, cs_fifo_a, cs_fifo_b, cs_usb_host};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // one bus cycle: inputs set at negedge, outputs sampled 1 ns after the next posedge
  task automatic cyc(input logic [22:0] a, input logic rd, input logic wr,
                     input logic [7:0] d, input logic reg_s, input logic boot_s);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d;
    region_sel = reg_s; boot_sel = boot_s;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(23'h0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic wr_reg(input logic [22:0] a, input logic [7:0] d);
    idle();
    cyc(a, 1'b0, 1'b1, d, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_reset();
    check("R11 selects", {26'd0, cs_vec()}, 32'd0);
    check("R11 oe", bus_rdata_oe, 0);
    check("R11 led", led, 8'h00);
    cyc(23'h600007, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R6 cfg reset value", bus_rdata, 8'h00);
    idle();
  endtask

  task automatic t_memories();
    cyc(23'h000000, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R1 fixed low", {26'd0, cs_vec()}, 32'b100000);
    cyc(23'h1FFFFF, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0);
    check("R1 fixed high", {26'd0, cs_vec()}, 32'b100000);
    cyc(23'h200000, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R2 socket low", {26'd0, cs_vec()}, 32'b010000);
    cyc(23'h3FFFFF, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R2 socket high", {26'd0, cs_vec()}, 32'b010000);
    cyc(23'h400000, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R3 sram low", {26'd0, cs_vec()}, 32'b001000);
    cyc(23'h5FFFFF, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0);
    check("R3 sram high", {26'd0, cs_vec()}, 32'b001000);
    check("R10 no oe on memory", bus_rdata_oe, 0);
    idle();
  endtask

  task automatic t_dev_regs();
    for (int k = 0; k < 6; k++) begin
      logic [5:0] exp_cs;
      exp_cs = 6'b000100 >> (k / 2);
      cyc(23'h600000 + 23'(k), 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
      check($sformatf("R4 select offset %0d", k), {26'd0, cs_vec()}, {26'd0, exp_cs});
      check($sformatf("R4 dev_ctrl offset %0d", k), dev_ctrl, k % 2);
      check($sformatf("R10 no oe offset %0d", k), bus_rdata_oe, 0);
    end
    idle();
  endtask

  task automatic t_led_dip();
    wr_reg(23'h600006, 8'hA5);
    check("R5 led latch", led, 8'hA5);
    dip_sw = 8'h3C;
    cyc(23'h600006, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R5 dip inverted", bus_rdata, 8'hC3);
    check("R10 oe on led read", bus_rdata_oe, 1);
    check("R9 no select for local", {26'd0, cs_vec()}, 32'd0);
    idle();
    // held strobe: only the rising edge writes
    cyc(23'h600006, 1'b0, 1'b1, 8'h11, 1'b1, 1'b0);
    cyc(23'h600006, 1'b0, 1'b1, 8'h22, 1'b1, 1'b0);
    cyc(23'h600006, 1'b0, 1'b1, 8'h33, 1'b1, 1'b0);
    check("R10 held strobe writes once", led, 8'h11);
    idle();
  endtask

  task automatic t_cfg_boot();
    wr_reg(23'h600007, 8'h5A);
    cyc(23'h600007, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R6 cfg readback", bus_rdata, 8'h5A);
    idle();
    board_strap = 1'b1;
    cyc(23'h000000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
    check("R7 boot to socket (bit0=0)", {26'd0, cs_vec()}, 32'b010000);
    // boot and region together: boot wins
    cyc(23'h000000, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1);
    check("R7 boot over region", {26'd0, cs_vec()}, 32'b010000);
    idle();
    // set bit0, boot access on the very next bus cycle
    cyc(23'h600007, 1'b0, 1'b1, 8'h01, 1'b1, 1'b0);
    cyc(23'h000000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
    check("R7 boot to sram (bit0=1)", {26'd0, cs_vec()}, 32'b001000);
    cyc(23'h000000, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1);
    check("R7 boot+region to sram", {26'd0, cs_vec()}, 32'b001000);
    idle();
  endtask

  task automatic t_strap();
    board_strap = 1'b0;
    cyc(23'h000000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
    check("R8 strap low boot ignored", {26'd0, cs_vec()}, 32'd0);
    cyc(23'h000000, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1);
    check("R8 strap low region decodes", {26'd0, cs_vec()}, 32'b100000);
    idle();
    board_strap = 1'b1;
  endtask

  task automatic t_holes();
    cyc(23'h600008, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R9 hole no select", {26'd0, cs_vec()}, 32'd0);
    check("R9 hole reads FF", bus_rdata, 8'hFF);
    check("R9 hole oe", bus_rdata_oe, 1);
    cyc(23'h7FFFFF, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R9 top hole reads FF", bus_rdata, 8'hFF);
    cyc(23'h400000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R9 no strobe no select", {26'd0, cs_vec()}, 32'd0);
    check("R10 no oe without read", bus_rdata_oe, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_memories();
    t_dev_regs();
    t_led_dip();
    t_cfg_boot();
    t_strap();
    t_holes();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule